// File: doc/BRIEF.md
# Sensor Scratchpad Register Controller

This block is the register side of a temperature sensor that sits as a slave on a single-wire serial bus. It keeps a nine-byte scratchpad: a two-byte temperature reading, two alarm or user bytes, a configuration byte, three fixed reserved bytes and a check byte. The check byte always holds the CRC of the eight bytes before it. The bus front end decodes the function commands and hands them over as a byte code. It then moves data through a bit-serial port, one bit per strobe, least significant bit first.

The two alarm bytes and the resolution field of the configuration byte can be copied into a shadow store and recalled from it. That store is modelled as a register bank with a fixed latency. While a recall runs, a read slot answers 0; once the recall is complete it answers 1. A conversion request starts a timer whose length depends on the resolution field. When the timer expires, a one-cycle done strobe is raised and the temperature bytes take the value presented on `temp_in`.

Top module: `sensor_scratchpad`

## Requirements
- R1: On reset the scratchpad reads, byte 0 first: 50h, 05h, TH_INIT, TL_INIT, the configuration byte built from RES_INIT, FFh, RSV6_VAL, 10h, CRC.
- R2: Code 4Eh opens a write. Bits arrive LSB first, one per `wr_bit_valid`, and fill byte 2, then byte 3, then byte 4. Each byte is stored as soon as its eighth bit arrives, so a write that ends early keeps only the complete bytes. Bits after the 24th are dropped.
- R3: The configuration byte (byte 4) always reads bit 7 = 0 and bits 4..0 = 1. Only bits 6..5 (the resolution field) take written data.
- R4: A write never alters bytes 0, 1 or 5 to 8. Bytes 5, 6 and 7 always read FFh, RSV6_VAL and 10h.
- R5: Byte 8 is the CRC with polynomial x^8+x^5+x^4+1 and initial value 0, taken over bytes 0..7 fed LSB first. Running all 72 scratchpad bits through that CRC therefore leaves 0.
- R6: Code BEh opens a read. Each `rd_slot` returns one bit on `rd_bit`, starting with bit 0 of byte 0, and then moves to the next bit. Slots after the 72nd bit return 1.
- R7: Code 48h copies bytes 2..4 into the shadow store. The copy completes NV_LAT cycles after the command.
- R8: Code B8h reloads bytes 2..4 from the shadow store. A read slot returns 0 for the NV_LAT cycles that follow the command and 1 after that, and the reloaded values are visible once the slots return 1.
- R9: A read slot returns 1 whenever no read and no recall is active, including during a write and during a copy.
- R10: While a copy or a recall is active, commands are ignored. A new command, `txn_end` or an unknown code ends a write or a read, and write bits that arrive outside a write have no effect.
- R11: `conv_start`, when no conversion is running, raises `conv_done` for one cycle exactly TCONV_CYC/8, /4, /2 or /1 cycles later, for a resolution field of 00, 01, 10 or 11. A start that arrives during a conversion is ignored.
- R12: The cycle after `conv_done` is high, byte 0 and byte 1 hold the low and high bytes of `temp_in` as it was during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded function command is present |
| cmd_code | input | 8 | Command code (4Eh, BEh, 48h, B8h) |
| txn_end | input | 1 | Ends the current write or read |
| wr_bit_valid | input | 1 | Strobe for one incoming data bit |
| wr_bit | input | 1 | Incoming data bit |
| rd_slot | input | 1 | Read slot: take `rd_bit` and advance |
| rd_bit | output | 1 | Bit returned in the current read slot |
| conv_start | input | 1 | Request a temperature conversion |
| temp_in | input | 16 | Conversion result, stored when it completes |
| conv_done | output | 1 | One-cycle pulse at the end of a conversion |

## Verification
Assertions check on every cycle that the write and read counters stay in range and that a recall state always has the shadow store busy. They also check that commands arriving during a copy cannot start anything else, that the resolution field changes only through a write or a completed recall, and that the done strobe lasts a single cycle. The bench scenarios cover what no single cycle can show. These are the byte values and their LSB-first order, the CRC residue, the early ending of a write, the round trip through copy and recall with its count of busy slots, and the conversion length for each resolution.

// File: rtl/sp_pkg.sv
// Shared types for the scratchpad controller: command codes, control
// states and the configuration byte layout. Assumes 8-bit command codes.
package sp_pkg;

    localparam logic [7:0] CMD_WRITE  = 8'h4E;
    localparam logic [7:0] CMD_READ   = 8'hBE;
    localparam logic [7:0] CMD_COPY   = 8'h48;
    localparam logic [7:0] CMD_RECALL = 8'hB8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_COPY,
        ST_RECALL
    } sp_state_e;

    // Configuration byte: bit 7 low, bits 6..5 resolution, bits 4..0 high.
    function automatic logic [7:0] cfg_byte(input logic [1:0] res);
        return {1'b0, res, 5'b11111};
    endfunction

endpackage

// File: rtl/sp_crc8.sv
// Combinational CRC-8 (x^8+x^5+x^4+1, reflected, initial value 0) over
// NBYTES bytes. Byte 0 occupies the lowest bits and every byte is taken
// LSB first. Assumes NBYTES is small enough to unroll.
module sp_crc8 #(
    parameter int NBYTES = 8
) (
    input  logic [8*NBYTES-1:0] data,
    output logic [7:0]          crc
);

    localparam int NBITS = 8 * NBYTES;

    logic [7:0] acc;

    // Shift each data bit through the reflected polynomial.
    always_comb begin
        acc = 8'h00;
        for (int i = 0; i < NBITS; i++) begin
            acc = {1'b0, acc[7:1]} ^ ({8{acc[0] ^ data[i]}} & 8'h8C);
        end
        crc = acc;
    end

endmodule

// File: rtl/sp_nvstore.sv
// Shadow store for the writable scratchpad bytes. A copy or a recall
// request starts a LAT-cycle busy window. At its last cycle a copy
// captures wr_data, and recall_done tells the owner to load rd_data.
// Requests made while busy are dropped. Assumes LAT >= 1.
module sp_nvstore #(
    parameter int             W    = 24,
    parameter int             LAT  = 20,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         copy_go,
    input  logic         recall_go,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         busy,
    output logic         finish,
    output logic         recall_done
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;
    logic          is_copy_q;
    logic [W-1:0]  store_q;

    // Latency counter, operation kind and stored contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            is_copy_q <= 1'b0;
            store_q   <= INIT;
        end else if (cnt_q == '0) begin
            if (copy_go || recall_go) begin
                cnt_q     <= CW'(LAT);
                is_copy_q <= copy_go;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1) && is_copy_q) store_q <= wr_data;
        end
    end

    // Status toward the owner.
    always_comb begin
        busy        = (cnt_q != '0);
        finish      = (cnt_q == CW'(1));
        recall_done = finish && !is_copy_q;
        rd_data     = store_q;
    end

    // R7
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(store_q));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (copy_go || recall_go)) |=> (is_copy_q == $past(is_copy_q)));

endmodule

// File: rtl/sp_conv_timer.sv
// Conversion timer. On start while idle it loads a period of TCONV
// cycles divided by 8, 4, 2 or 1 for a resolution of 00..11 and counts
// down. One cycle after the count expires it pulses done. Starts made
// while counting are dropped. Assumes TCONV >= 16.
module sp_conv_timer #(
    parameter int TCONV = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] res,
    output logic       done
);

    localparam int CW = $clog2(TCONV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;
    logic          done_q;

    // Period chosen by the resolution field.
    always_comb begin
        case (res)
            2'b00:   period = CW'(TCONV / 8);
            2'b01:   period = CW'(TCONV / 4);
            2'b10:   period = CW'(TCONV / 2);
            default: period = CW'(TCONV);
        endcase
    end

    // Down counter and registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (cnt_q == CW'(1));
            if (cnt_q == '0) begin
                if (start) cnt_q <= period;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = done_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt_q > CW'(1)) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/sensor_scratchpad.sv
// Scratchpad register controller for a serial-bus temperature sensor.
// It takes decoded function commands, moves data bit-serially LSB
// first, keeps the CRC byte current, drives a shadow store with copy and
// recall, and times conversions from the resolution field. Assumes the
// bus front end gives at most one strobe per cycle.
module sensor_scratchpad
    import sp_pkg::*;
#(
    parameter int         TCONV_CYC = 800,
    parameter int         NV_LAT    = 20,
    parameter logic [7:0] TH_INIT   = 8'h4B,
    parameter logic [7:0] TL_INIT   = 8'h46,
    parameter logic [1:0] RES_INIT  = 2'b11,
    parameter logic [7:0] RSV6_VAL  = 8'h0C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_code,
    input  logic        txn_end,
    input  logic        wr_bit_valid,
    input  logic        wr_bit,
    input  logic        rd_slot,
    output logic        rd_bit,
    input  logic        conv_start,
    input  logic [15:0] temp_in,
    output logic        conv_done
);

    localparam int NBODY  = 8;
    localparam int NBITS  = 8 * (NBODY + 1);
    localparam int PW     = $clog2(NBITS + 1);
    localparam int WRBITS = 24;

    sp_state_e    state_q;
    logic [15:0]  temp_q;
    logic [7:0]   th_q, tl_q;
    logic [1:0]   res_q;
    logic [4:0]   wr_cnt_q;
    logic [7:0]   wr_sh_q;
    logic [PW-1:0] rd_ptr_q;

    logic [8*NBODY-1:0] body_w;
    logic [7:0]   crc_w;
    logic [NBITS-1:0] frame_w;
    logic         busy_state, cmd_ok, copy_go, recall_go;
    logic [23:0]  nv_rd;
    logic         nv_busy, nv_finish, nv_recall_done;
    logic [7:0]   wr_byte;

    // Scratchpad image: byte 0 in the low bits, check byte on top.
    always_comb begin
        body_w  = {8'h10, RSV6_VAL, 8'hFF, cfg_byte(res_q), tl_q, th_q, temp_q};
        frame_w = {crc_w, body_w};
    end

    sp_crc8 #(.NBYTES(NBODY)) crc_i (
        .data (body_w),
        .crc  (crc_w)
    );

    // Command acceptance and shadow-store requests.
    always_comb begin
        busy_state = (state_q == ST_COPY) || (state_q == ST_RECALL);
        cmd_ok     = cmd_valid && !busy_state;
        copy_go    = cmd_ok && (cmd_code == CMD_COPY);
        recall_go  = cmd_ok && (cmd_code == CMD_RECALL);
        wr_byte    = {wr_bit, wr_sh_q[7:1]};
    end

    sp_nvstore #(
        .W    (24),
        .LAT  (NV_LAT),
        .INIT ({cfg_byte(RES_INIT), TL_INIT, TH_INIT})
    ) nv_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .copy_go     (copy_go),
        .recall_go   (recall_go),
        .wr_data     ({cfg_byte(res_q), tl_q, th_q}),
        .rd_data     (nv_rd),
        .busy        (nv_busy),
        .finish      (nv_finish),
        .recall_done (nv_recall_done)
    );

    sp_conv_timer #(.TCONV(TCONV_CYC)) conv_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .res   (res_q),
        .done  (conv_done)
    );

    // Bit returned by a read slot in the current state.
    always_comb begin
        case (state_q)
            ST_READ:   rd_bit = (rd_ptr_q < PW'(NBITS)) ? frame_w[rd_ptr_q] : 1'b1;
            ST_RECALL: rd_bit = 1'b0;
            default:   rd_bit = 1'b1;
        endcase
    end

    // Control state, serial write assembly, read pointer and stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            temp_q   <= 16'h0550;
            th_q     <= TH_INIT;
            tl_q     <= TL_INIT;
            res_q    <= RES_INIT;
            wr_cnt_q <= '0;
            wr_sh_q  <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (conv_done) temp_q <= temp_in;
            if (cmd_ok) begin
                case (cmd_code)
                    CMD_WRITE:  begin state_q <= ST_WRITE; wr_cnt_q <= '0; end
                    CMD_READ:   begin state_q <= ST_READ;  rd_ptr_q <= '0; end
                    CMD_COPY:   state_q <= ST_COPY;
                    CMD_RECALL: state_q <= ST_RECALL;
                    default:    state_q <= ST_IDLE;
                endcase
            end else if (txn_end && (state_q == ST_WRITE || state_q == ST_READ)) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_WRITE: if (wr_bit_valid && wr_cnt_q < 5'(WRBITS)) begin
                        wr_sh_q  <= wr_byte;
                        wr_cnt_q <= wr_cnt_q + 1'b1;
                        if (wr_cnt_q[2:0] == 3'd7) begin
                            case (wr_cnt_q[4:3])
                                2'd0:    th_q  <= wr_byte;
                                2'd1:    tl_q  <= wr_byte;
                                default: res_q <= wr_byte[6:5];
                            endcase
                        end
                    end
                    ST_READ: if (rd_slot && rd_ptr_q < PW'(NBITS)) rd_ptr_q <= rd_ptr_q + 1'b1;
                    ST_COPY: if (nv_finish) state_q <= ST_IDLE;
                    ST_RECALL: if (nv_recall_done) begin
                        th_q    <= nv_rd[7:0];
                        tl_q    <= nv_rd[15:8];
                        res_q   <= nv_rd[22:21];
                        state_q <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    wr_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_q <= 5'(WRBITS));

    // R6
    rd_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_q <= PW'(NBITS));

    // R8
    recall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECALL) |-> nv_busy);

    // R10
    copy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COPY && cmd_valid) |=> (state_q == ST_COPY || state_q == ST_IDLE));

    // R3
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_bit_valid && state_q == ST_WRITE) && !nv_recall_done) |=> $stable(res_q));

endmodule

// File: tb/sensor_scratchpad_tb_top.sv
// Bench for sensor_scratchpad: a behavioural reference model runs beside
// the design and is compared on every clock, and directed scenarios
// check byte values, CRC residue, copy/recall and conversion timing.
module sensor_scratchpad_tb_top;

    localparam int TCONV  = 160;
    localparam int NVL    = 12;
    localparam int WDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        txn_end = 1'b0;
    logic        wr_bit_valid = 1'b0;
    logic        wr_bit = 1'b0;
    logic        rd_slot = 1'b0;
    logic        rd_bit;
    logic        conv_start = 1'b0;
    logic [15:0] temp_in = 16'h0000;
    logic        conv_done;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    logic [72:0] frm;

    sensor_scratchpad #(
        .TCONV_CYC (TCONV),
        .NV_LAT    (NVL)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .txn_end      (txn_end),
        .wr_bit_valid (wr_bit_valid),
        .wr_bit       (wr_bit),
        .rd_slot      (rd_slot),
        .rd_bit       (rd_bit),
        .conv_start   (conv_start),
        .temp_in      (temp_in),
        .conv_done    (conv_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_state, m_wcnt, m_wbyte, m_ptr, m_nvc, m_conv;
    int m_sp[8];
    int m_nv[3];
    int m_res, m_nvres;
    bit m_done;

    function automatic int crc_bits(input logic [71:0] bits, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            int fb = (c & 1) ^ int'(bits[i]);
            c = c >> 1;
            if (fb != 0) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [71:0] m_frame();
        logic [71:0] f;
        for (int b = 0; b < 8; b++) f[8*b +: 8] = m_sp[b][7:0];
        m_sp[4] = 32'h1F | (m_res << 5);
        for (int b = 0; b < 8; b++) f[8*b +: 8] = m_sp[b][7:0];
        f[71:64] = 8'(crc_bits(f, 64));
        return f;
    endfunction

    function automatic bit m_bit();
        logic [71:0] f;
        if (m_state == 4) return 1'b0;
        if (m_state != 2 || m_ptr >= 72) return 1'b1;
        f = m_frame();
        return f[m_ptr];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_wcnt = 0; m_wbyte = 0; m_ptr = 0; m_nvc = 0; m_conv = 0;
            m_sp[0] = 8'h50; m_sp[1] = 8'h05; m_sp[2] = 8'h4B; m_sp[3] = 8'h46;
            m_sp[5] = 8'hFF; m_sp[6] = 8'h0C; m_sp[7] = 8'h10;
            m_res = 3; m_nv[0] = 8'h4B; m_nv[1] = 8'h46; m_nvres = 3; m_done = 1'b0;
        end else begin
            bit nd;
            if (m_done) begin m_sp[0] = int'(temp_in[7:0]); m_sp[1] = int'(temp_in[15:8]); end
            nd = (m_conv == 1);
            if (m_conv == 0) begin
                if (conv_start) m_conv = TCONV >> (3 - m_res);
            end else m_conv--;
            m_done = nd;
            if (cmd_valid && m_state != 3 && m_state != 4) begin
                case (cmd_code)
                    8'h4E: begin m_state = 1; m_wcnt = 0; end
                    8'hBE: begin m_state = 2; m_ptr = 0; end
                    8'h48: begin m_state = 3; m_nvc = NVL; end
                    8'hB8: begin m_state = 4; m_nvc = NVL; end
                    default: m_state = 0;
                endcase
            end else if (txn_end && (m_state == 1 || m_state == 2)) begin
                m_state = 0;
            end else if (m_state == 1) begin
                if (wr_bit_valid && m_wcnt < 24) begin
                    m_wbyte = (m_wbyte >> 1) | (int'(wr_bit) << 7);
                    m_wcnt++;
                    if (m_wcnt % 8 == 0) begin
                        if (m_wcnt == 8) m_sp[2] = m_wbyte;
                        else if (m_wcnt == 16) m_sp[3] = m_wbyte;
                        else m_res = (m_wbyte >> 5) & 3;
                    end
                end
            end else if (m_state == 2) begin
                if (rd_slot && m_ptr < 72) m_ptr++;
            end else if (m_state == 3 || m_state == 4) begin
                m_nvc--;
                if (m_nvc == 0) begin
                    if (m_state == 3) begin m_nv[0] = m_sp[2]; m_nv[1] = m_sp[3]; m_nvres = m_res; end
                    else begin m_sp[2] = m_nv[0]; m_sp[3] = m_nv[1]; m_res = m_nvres; end
                    m_state = 0;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (rd_slot) chk({cur_req, " rd_bit model"}, int'(rd_bit), int'(m_bit()));
            chk("R11 conv_done model", int'(conv_done), int'(m_done));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic end_txn();
        @(negedge clk); txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_bit_valid = 1'b1; wr_bit = b[i];
        end
        @(negedge clk); wr_bit_valid = 1'b0;
    endtask

    task automatic write_pad(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        send_cmd(8'h4E);
        send_bits(a, 8); send_bits(b, 8); send_bits(c, 8);
        end_txn();
    endtask

    task automatic read_pad();
        send_cmd(8'hBE);
        for (int i = 0; i < 73; i++) begin
            @(negedge clk); rd_slot = 1'b1; #2; frm[i] = rd_bit;
        end
        @(negedge clk); rd_slot = 1'b0;
        end_txn();
    endtask

    task automatic slot_once(output logic v);
        @(negedge clk); rd_slot = 1'b1; #2; v = rd_bit;
        @(negedge clk); rd_slot = 1'b0;
    endtask

    task automatic recall_count(output int zeros, output logic last);
        zeros = 0;
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'hB8;
        @(negedge clk); cmd_valid = 1'b0; rd_slot = 1'b1;
        for (int k = 0; k < NVL + 4; k++) begin
            #2; if (rd_bit == 1'b0) zeros++;
            last = rd_bit;
            @(negedge clk);
        end
        rd_slot = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic v;
        int   z;
        logic lst;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R4 R5 R6: reset image, byte order and CRC residue
        cur_req = "R6";
        read_pad();
        chk("R1 byte0", int'(frm[7:0]), 8'h50);
        chk("R1 byte1", int'(frm[15:8]), 8'h05);
        chk("R1 byte2", int'(frm[23:16]), 8'h4B);
        chk("R1 byte3", int'(frm[31:24]), 8'h46);
        chk("R1 byte4", int'(frm[39:32]), 8'h7F);
        chk("R4 byte5", int'(frm[47:40]), 8'hFF);
        chk("R4 byte6", int'(frm[55:48]), 8'h0C);
        chk("R4 byte7", int'(frm[63:56]), 8'h10);
        chk("R5 residue", crc_bits(frm[71:0], 72), 0);
        chk("R6 past end", int'(frm[72]), 1);

        // R9: idle slot
        cur_req = "R9";
        slot_once(v);
        chk("R9 idle slot", int'(v), 1);

        // R2 R3 R4: full write plus one extra byte
        cur_req = "R2";
        send_cmd(8'h4E);
        send_bits(8'h12, 8); send_bits(8'hEE, 8); send_bits(8'h40, 8);
        slot_once(v);
        chk("R9 slot during write", int'(v), 1);
        send_bits(8'h99, 8);
        end_txn();
        read_pad();
        chk("R2 byte2", int'(frm[23:16]), 8'h12);
        chk("R2 byte3", int'(frm[31:24]), 8'hEE);
        chk("R3 cfg 40h reads", int'(frm[39:32]), 8'h5F);
        chk("R4 byte0 kept", int'(frm[7:0]), 8'h50);
        chk("R4 byte5 kept", int'(frm[47:40]), 8'hFF);
        chk("R5 residue", crc_bits(frm[71:0], 72), 0);

        // R2 R10: short write, then stray bits outside a write
        send_cmd(8'h4E);
        send_bits(8'h77, 8); send_bits(8'h05, 3);
        end_txn();
        send_bits(8'h00, 8);
        read_pad();
        chk("R2 short byte2", int'(frm[23:16]), 8'h77);
        chk("R2 short byte3", int'(frm[31:24]), 8'hEE);
        chk("R10 stray bits", int'(frm[23:16]), 8'h77);

        // R7 R8 R9: copy, overwrite, recall
        cur_req = "R7";
        send_cmd(8'h48);
        slot_once(v);
        chk("R9 slot during copy", int'(v), 1);
        repeat (NVL + 2) @(negedge clk);
        write_pad(8'h01, 8'h02, 8'h00);
        read_pad();
        chk("R3 cfg 00h reads", int'(frm[39:32]), 8'h1F);
        cur_req = "R8";
        recall_count(z, lst);
        chk("R8 busy slots", z, NVL);
        chk("R8 done slot", int'(lst), 1);
        read_pad();
        chk("R7 byte2 restored", int'(frm[23:16]), 8'h77);
        chk("R7 byte3 restored", int'(frm[31:24]), 8'hEE);
        chk("R7 byte4 restored", int'(frm[39:32]), 8'h5F);

        // R10: read command during recall is dropped
        cur_req = "R10";
        send_cmd(8'hB8);
        send_cmd(8'hBE);
        repeat (NVL + 4) @(negedge clk);
        slot_once(v);
        chk("R10 cmd during recall", int'(v), 1);

        // R11 R12: conversion length per resolution
        cur_req = "R11";
        for (int r = 0; r < 4; r++) begin
            int k;
            bit seen;
            write_pad(8'h77, 8'hEE, 8'(r << 5));
            temp_in = 16'h1100 | 16'(r);
            @(negedge clk); conv_start = 1'b1;
            @(negedge clk); conv_start = 1'b0;
            k = 0; seen = 1'b0;
            while (!seen && k < TCONV + 10) begin
                #2;
                if (conv_done) seen = 1'b1;
                else begin
                    @(negedge clk);
                    conv_start = (r == 3 && k == 4);
                    k++;
                end
            end
            chk("R11 period", k, TCONV >> (3 - r));
            @(negedge clk); conv_start = 1'b0; #2;
            chk("R11 one-cycle done", int'(conv_done), 0);
            temp_in = 16'hFFFF;
            read_pad();
            chk("R12 byte0", int'(frm[7:0]), r);
            chk("R12 byte1", int'(frm[15:8]), 8'h11);
        end

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule